// File: doc/BRIEF.md
# Dynamic Priority Memory Request Arbiter

This block decides which pending memory request is handed the next DRAM access. A fixed set of requesters, one of them the refresh scheduler, each own a single holding slot. A requester offers a request with a row address and an urgency flag. The block takes the request whenever that requester's slot is empty. Once in its slot, the request waits until it is granted.

Each cycle the block scores every occupied slot and grants the best score through a one-hot vector. The score adds four parts: a base weight set per requester, a bonus for urgency, a bonus when the request's row matches the row the controller currently holds open, and the number of cycles the request has waited, which stops growing at a ceiling. An urgent refresh request is placed above every other request by a flag bit above the sum. Equal scores go to the lowest slot index. A granted slot empties at the next clock edge and may take a new request in the cycle after that.

Top module: `dram_prio_arbiter`

## Requirements
- R1: `reqReady[i]` is high exactly when slot i is empty. A request offered while ready is taken at that clock edge, and from the following cycle it takes part in arbitration.
- R2: `grantOneHot` has at most one bit set. It is all zero exactly when no slot is occupied, and it is nonzero whenever any slot is occupied.
- R3: The granted slot has the highest score among occupied slots. The score of slot i is `BASE_WEIGHTS[i*BASE_W +: BASE_W]` plus `URGENT_BONUS` if urgent, plus `HIT_BONUS` on a row hit, plus the slot's age.
- R4: When two or more occupied slots share the highest score, the lowest index among them is granted.
- R5: A slot's age is zero on the cycle after its request is taken. It rises by one for each cycle the slot stays occupied without a grant, and it holds at 2^AGE_W-1.
- R6: A slot granted in one cycle is empty in the next cycle, so its `reqReady` is high again.
- R7: While the slot at `REFRESH_IDX` holds an urgent request, that slot is granted, whatever the scores of the other slots.
- R8: A row hit means `openRowValid` is high and the slot's row equals `openRow`. When `openRowValid` is low, no slot earns the row-hit bonus.
- R9: During and right after reset every slot is empty, every `reqReady` is high and `grantOneHot` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | NUM_REQ | Request offered, one bit per requester |
| reqReady | output | NUM_REQ | Slot empty, so an offered request is taken |
| reqUrgent | input | NUM_REQ | Urgency flag carried with each request |
| reqRow | input | NUM_REQ*ROW_W | Row address per requester, requester i at bits i*ROW_W upward |
| openRowValid | input | 1 | A row is currently open |
| openRow | input | ROW_W | Address of the open row |
| grantOneHot | output | NUM_REQ | Slot granted this cycle |

## Verification
The bench builds the block with four requesters, a 4-bit row, base weights of 6, 6, 0 and 1 (refresh at index 3), an urgent bonus of 5 and a hit bonus of 3. It uses a 2-bit age that tops out at 3. With a row that narrow, random traffic hits the open row often. With an age that short, a base-0 request left behind two busy base-6 requesters visibly stays starved once its age saturates. Under the same weights, an urgent refresh competes against a slot whose urgent plus hit sum is higher, which shows that the flag bit, and not the sum, decides that case.

// File: rtl/darb_pkg.sv
package darb_pkg;
  localparam int MAX_REQ = 16;
  localparam int IDX_W   = $clog2(MAX_REQ);

  typedef struct packed {
    logic             grantValid;
    logic [IDX_W-1:0] grantIdx;
  } grant_strobe_t;
endpackage

// File: rtl/darb_slots.sv
module darb_slots #(
  parameter int NUM_REQ      = 4,
  parameter int ROW_W        = 8,
  parameter int AGE_W        = 4,
  parameter int BASE_W       = 4,
  parameter int BONUS_W      = 4,
  parameter logic [NUM_REQ*BASE_W-1:0] BASE_WEIGHTS = '0,
  parameter logic [BONUS_W-1:0] URGENT_BONUS = 4,
  parameter logic [BONUS_W-1:0] HIT_BONUS    = 3,
  parameter int REFRESH_IDX  = NUM_REQ-1,
  localparam int TERM_W  = (BASE_W > AGE_W) ? ((BASE_W > BONUS_W) ? BASE_W : BONUS_W)
                                            : ((AGE_W > BONUS_W) ? AGE_W : BONUS_W),
  localparam int SUM_W   = TERM_W + 2,
  localparam int SCORE_W = SUM_W + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_REQ-1:0]            reqValid,
  input  logic [NUM_REQ-1:0]            reqUrgent,
  input  logic [NUM_REQ*ROW_W-1:0]      reqRow,
  input  logic                          openRowValid,
  input  logic [ROW_W-1:0]              openRow,
  input  darb_pkg::grant_strobe_t       ctrl,
  output logic [NUM_REQ-1:0]            reqReady,
  output logic [NUM_REQ-1:0]            slotValid,
  output logic [NUM_REQ-1:0][SCORE_W-1:0] slotScore,
  output logic [NUM_REQ-1:0]            grantOneHot
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [NUM_REQ-1:0]            urgentQ;
  logic [NUM_REQ-1:0][ROW_W-1:0] rowQ;
  logic [NUM_REQ-1:0][AGE_W-1:0] ageQ;
  logic [NUM_REQ-1:0]            rowHit;
  logic [NUM_REQ-1:0]            loadSlot;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
    localparam logic [BASE_W-1:0] BASE = BASE_WEIGHTS[i*BASE_W +: BASE_W];
    logic [SUM_W-1:0] sumTerm;

    assign grantOneHot[i] = ctrl.grantValid && (ctrl.grantIdx == darb_pkg::IDX_W'(i));
    assign reqReady[i]    = !slotValid[i];
    assign loadSlot[i]    = reqValid[i] && !slotValid[i];
    assign rowHit[i]      = openRowValid && (rowQ[i] == openRow);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[i] <= 1'b0;
        urgentQ[i]   <= 1'b0;
        rowQ[i]      <= '0;
        ageQ[i]      <= '0;
      end else if (loadSlot[i]) begin
        slotValid[i] <= 1'b1;
        urgentQ[i]   <= reqUrgent[i];
        rowQ[i]      <= reqRow[i*ROW_W +: ROW_W];
        ageQ[i]      <= '0;
      end else if (grantOneHot[i]) begin
        slotValid[i] <= 1'b0;
        ageQ[i]      <= '0;
      end else if (slotValid[i] && ageQ[i] != AGE_MAX) begin
        ageQ[i]      <= ageQ[i] + 1'b1;
      end
    end

    always_comb begin
      sumTerm = SUM_W'(BASE) + SUM_W'(ageQ[i]);
      if (urgentQ[i]) sumTerm = sumTerm + SUM_W'(URGENT_BONUS);
      if (rowHit[i])  sumTerm = sumTerm + SUM_W'(HIT_BONUS);
    end

    if (i == REFRESH_IDX) begin : g_refresh
      assign slotScore[i] = {urgentQ[i], sumTerm};
    end else begin : g_master
      assign slotScore[i] = {1'b0, sumTerm};
    end

    assert_take_request_R1: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[i] && reqReady[i]) |=> slotValid[i]);
    assert_age_start_R5: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[i] && reqReady[i]) |=> (ageQ[i] == '0));
    assert_age_step_R5: assert property (@(posedge clk) disable iff (!rstN)
      (slotValid[i] && !grantOneHot[i] && ageQ[i] != AGE_MAX) |=> (ageQ[i] == $past(ageQ[i]) + 1'b1));
    assert_age_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      (slotValid[i] && !grantOneHot[i] && ageQ[i] == AGE_MAX) |=> (ageQ[i] == AGE_MAX));
    assert_slot_freed_R6: assert property (@(posedge clk) disable iff (!rstN)
      grantOneHot[i] |=> !slotValid[i]);
    assert_grant_occupied_R2: assert property (@(posedge clk) disable iff (!rstN)
      grantOneHot[i] |-> slotValid[i]);
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOneHot));
  assert_urgent_refresh_R7: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid[REFRESH_IDX] && urgentQ[REFRESH_IDX]) |-> grantOneHot[REFRESH_IDX]);
  assert_reset_state_R9: assert property (@(posedge clk)
    $rose(rstN) |-> (grantOneHot == '0));
endmodule

// File: rtl/darb_pick.sv
module darb_pick #(
  parameter int NUM_REQ = 4,
  parameter int SCORE_W = 7
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_REQ-1:0]              slotValid,
  input  logic [NUM_REQ-1:0][SCORE_W-1:0] slotScore,
  output darb_pkg::grant_strobe_t         ctrl
);
  localparam int IDX_W = darb_pkg::IDX_W;

  if (NUM_REQ > darb_pkg::MAX_REQ) begin : g_too_many
    $error("NUM_REQ exceeds the supported requester count");
  end

  logic [SCORE_W-1:0] bestScore;
  logic [IDX_W-1:0]   bestIdx;
  logic               found;

  always_comb begin
    found     = 1'b0;
    bestScore = '0;
    bestIdx   = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (slotValid[i] && (!found || slotScore[i] > bestScore)) begin
        found     = 1'b1;
        bestScore = slotScore[i];
        bestIdx   = IDX_W'(i);
      end
    end
    ctrl.grantValid = found;
    ctrl.grantIdx   = bestIdx;
  end

  assert_grant_when_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid != '0) |-> ctrl.grantValid);
  assert_idle_no_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid == '0) |-> !ctrl.grantValid);

  for (genvar j = 0; j < NUM_REQ; j++) begin : g_chk
    assert_lower_loses_R4: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.grantValid && slotValid[j] && IDX_W'(j) < ctrl.grantIdx) |-> (slotScore[j] < bestScore));
    assert_higher_not_better_R3: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.grantValid && slotValid[j] && IDX_W'(j) > ctrl.grantIdx) |-> (slotScore[j] <= bestScore));
  end
endmodule

// File: rtl/dram_prio_arbiter.sv
module dram_prio_arbiter #(
  parameter int NUM_REQ      = 4,
  parameter int ROW_W        = 8,
  parameter int AGE_W        = 4,
  parameter int BASE_W       = 4,
  parameter int BONUS_W      = 4,
  parameter logic [NUM_REQ*BASE_W-1:0] BASE_WEIGHTS = {4'd1, 4'd0, 4'd1, 4'd2},
  parameter logic [BONUS_W-1:0] URGENT_BONUS = 4,
  parameter logic [BONUS_W-1:0] HIT_BONUS    = 3,
  parameter int REFRESH_IDX  = NUM_REQ-1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_REQ-1:0]       reqValid,
  output logic [NUM_REQ-1:0]       reqReady,
  input  logic [NUM_REQ-1:0]       reqUrgent,
  input  logic [NUM_REQ*ROW_W-1:0] reqRow,
  input  logic                     openRowValid,
  input  logic [ROW_W-1:0]         openRow,
  output logic [NUM_REQ-1:0]       grantOneHot
);
  localparam int TERM_W  = (BASE_W > AGE_W) ? ((BASE_W > BONUS_W) ? BASE_W : BONUS_W)
                                            : ((AGE_W > BONUS_W) ? AGE_W : BONUS_W);
  localparam int SCORE_W = TERM_W + 3;

  darb_pkg::grant_strobe_t                ctrl;
  logic [NUM_REQ-1:0]                     slotValid;
  logic [NUM_REQ-1:0][SCORE_W-1:0]        slotScore;

  darb_slots #(
    .NUM_REQ(NUM_REQ), .ROW_W(ROW_W), .AGE_W(AGE_W), .BASE_W(BASE_W), .BONUS_W(BONUS_W),
    .BASE_WEIGHTS(BASE_WEIGHTS), .URGENT_BONUS(URGENT_BONUS), .HIT_BONUS(HIT_BONUS),
    .REFRESH_IDX(REFRESH_IDX)
  ) u_slots (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqUrgent(reqUrgent), .reqRow(reqRow),
    .openRowValid(openRowValid), .openRow(openRow), .ctrl(ctrl), .reqReady(reqReady),
    .slotValid(slotValid), .slotScore(slotScore), .grantOneHot(grantOneHot)
  );

  darb_pick #(.NUM_REQ(NUM_REQ), .SCORE_W(SCORE_W)) u_pick (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotScore(slotScore), .ctrl(ctrl)
  );
endmodule

// File: tb/dram_prio_arbiter_tb.sv
module dram_prio_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int RW = 4;
  localparam int AGE_MAX = 3;
  localparam int URG = 5;
  localparam int HIT = 3;
  localparam int REF = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] reqValid = '0, reqUrgent = '0, reqReady, grantOneHot;
  logic [N*RW-1:0] reqRow = '0;
  logic openRowValid = 1'b0;
  logic [RW-1:0] openRow = '0;

  int testCount = 0, failCount = 0;
  bit mValid[N];
  bit mUrg[N];
  int mRow[N];
  int mAge[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_prio_arbiter #(
    .NUM_REQ(N), .ROW_W(RW), .AGE_W(2), .BASE_W(4), .BONUS_W(4),
    .BASE_WEIGHTS({4'd1, 4'd0, 4'd6, 4'd6}), .URGENT_BONUS(4'd5), .HIT_BONUS(4'd3),
    .REFRESH_IDX(REF)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqUrgent(reqUrgent),
    .reqRow(reqRow), .openRowValid(openRowValid), .openRow(openRow), .grantOneHot(grantOneHot)
  );

  function automatic int baseOf(int i);
    case (i)
      0: return 6;
      1: return 6;
      2: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [N-1:0] expGrant();
    int best = -1;
    int bestIdx = 0;
    for (int i = 0; i < N; i++) begin
      if (mValid[i]) begin
        int s = baseOf(i) + mAge[i] + (mUrg[i] ? URG : 0)
              + ((openRowValid && mRow[i] == int'(openRow)) ? HIT : 0)
              + ((i == REF && mUrg[i]) ? 1000 : 0);
        if (s > best) begin best = s; bestIdx = i; end
      end
    end
    return (best < 0) ? '0 : (N'(1) << bestIdx);
  endfunction

  function automatic logic [N-1:0] expReady();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = !mValid[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] v, input logic [N-1:0] u, input logic [N*RW-1:0] rows,
                      input logic orv, input logic [RW-1:0] orow, input string tag);
    logic [N-1:0] g;
    bit wasValid[N];
    @(negedge clk);
    reqValid = v; reqUrgent = u; reqRow = rows; openRowValid = orv; openRow = orow;
    #1;
    g = expGrant();
    check({tag, " grant"}, grantOneHot, g);
    check("R1 R6 ready", reqReady, expReady());
    for (int i = 0; i < N; i++) wasValid[i] = mValid[i];
    for (int i = 0; i < N; i++) begin
      if (g[i]) begin mValid[i] = 0; mAge[i] = 0; end
      else if (mValid[i] && mAge[i] < AGE_MAX) mAge[i]++;
      if (v[i] && !wasValid[i]) begin
        mValid[i] = 1; mUrg[i] = u[i]; mRow[i] = int'(rows[i*RW +: RW]); mAge[i] = 0;
      end
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 6; k++) step('0, '0, '0, 1'b0, '0, "R2");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mUrg[i] = 0; mRow[i] = 0; mAge[i] = 0; end
    repeat (3) @(negedge clk);
    check("R9 reset grant", grantOneHot, '0);
    check("R9 reset ready", reqReady, '1);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R9 after reset ready", reqReady, '1);

    drain();
    // R4: equal scores on slots 0 and 1
    step(4'b0011, '0, {4'd0, 4'd0, 4'd2, 4'd1}, 1'b0, '0, "R4");
    step('0, '0, '0, 1'b0, '0, "R4");
    step('0, '0, '0, 1'b0, '0, "R4");
    drain();
    // R7: urgent refresh vs urgent row-hit master
    step(4'b1001, 4'b1001, {4'd9, 4'd0, 4'd0, 4'd5}, 1'b1, 4'd5, "R7");
    step('0, '0, '0, 1'b1, 4'd5, "R7");
    step('0, '0, '0, 1'b1, 4'd5, "R7");
    drain();
    // R8: hit bonus lifts base-0 slot above refresh; no open row reverses it
    step(4'b1100, '0, {4'd3, 4'd7, 4'd0, 4'd0}, 1'b1, 4'd7, "R8");
    step('0, '0, '0, 1'b1, 4'd7, "R8");
    drain();
    step(4'b1100, '0, {4'd3, 4'd7, 4'd0, 4'd0}, 1'b0, 4'd7, "R8");
    step('0, '0, '0, 1'b0, 4'd7, "R8");
    drain();
    // R5: base-0 slot starved behind two busy base-6 slots once age saturates
    step(4'b0111, '0, '0, 1'b0, '0, "R5");
    for (int k = 0; k < 16; k++) begin
      step(4'b0011, '0, '0, 1'b0, '0, "R5");
      check("R5 starved slot", grantOneHot & 4'b0100, '0);
    end
    drain();
    // R3: random traffic
    for (int k = 0; k < 600; k++) begin
      logic [N-1:0] v = N'($urandom);
      logic [N-1:0] u = N'($urandom) & N'($urandom);
      logic [N*RW-1:0] rows = (N*RW)'($urandom) & {N{4'b0011}};
      step(v, u, rows, 1'(($urandom % 4) != 0), RW'($urandom % 4), "R3");
    end
    drain();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule